// File: doc/BRIEF.md
# Audio bit and frame clock generator

This block derives the bit timing of an audio serial port. It picks one of two source strobes: an auxiliary tick or a fixed high-rate tick. A first counter divides the chosen strobe by a programmable ratio to produce bit-clock enable pulses and a square-wave bit clock. A second counter divides those bit periods by another ratio to produce a frame-sync level that lasts one bit period per frame.

Both sources arrive as single-cycle enable strobes in the one system clock domain. All three settings live in a single 16-bit control word. Software writes it in one cycle. Each write restarts both dividers, so the new timing begins on a clean period boundary.

Top module: `audio_clkgen`

## Requirements
- R1: While rst_ni is low, all outputs are 0. After reset the control word is zero: auxiliary source, bit ratio 1 and frame ratio 1.
- R2: Control bit 0 picks the source. A 0 selects aux_tick_i and a 1 selects fast_tick_i. Strobes on the unselected input have no effect on any output.
- R3: With N held in control bits 15:8, bclk_en_o is high for one cycle, in the cycle after every (N+1)-th selected strobe. With N = 0, every selected strobe gives a pulse.
- R4: With F held in control bits 7:1, fsync_o changes only in the cycle in which bclk_en_o is high. On the bit-period end that completes every (F+1)-th bit period, it goes high and stays high for one bit period.
- R5: A cycle with cfg_we_i high loads cfg_wdata_i and clears both counters. In the next cycle all three outputs are 0. A selected strobe in the write cycle is not counted, so the first bit period after the write is a full N+1 strobes. This also holds when only the source bit changes.
- R6: bclk_o changes only after a selected strobe. After a strobe, it is high when the strobe's position within the bit period (0 at the start) is below ceil((N+1)/2), and low otherwise.
- R7: With F = 0, fsync_o stays high continuously once the first bit period has completed.
- R8: With N = 1 and F = 127, exactly one frame-sync bit period occurs per 128 bit periods. This is the 8 kHz frame from a 1024 kHz bit clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| aux_tick_i | input | 1 | Auxiliary source strobe |
| fast_tick_i | input | 1 | High-rate source strobe |
| cfg_we_i | input | 1 | Control word write strobe |
| cfg_wdata_i | input | 16 | Control word: [15:8] bit ratio-1, [7:1] frame ratio-1, [0] source |
| bclk_en_o | output | 1 | One-cycle pulse at each bit-period end |
| bclk_o | output | 1 | Square-wave bit clock level |
| fsync_o | output | 1 | Frame sync, high for one bit period per frame |

## Verification
The hardest case to reach is a write that lands in the same cycle as a selected strobe while both counters are mid-period. It is harder still when the write flips the source, because the strobe must be discarded and a full period must follow on the other input. The stimulus drives both sources at random densities and issues writes at random cycles. Some writes change only the source bit, so these collisions occur many times. A behavioural period model then checks every output on every cycle.

// File: rtl/audio_clkgen_pkg.sv
package audio_clkgen_pkg;
  parameter int unsigned BDIV_W = 8;
  parameter int unsigned FDIV_W = 7;
  parameter int unsigned CFG_W  = BDIV_W + FDIV_W + 1;

  // field order fixes the control word layout: [15:8] bit, [7:1] frame, [0] source
  typedef struct packed {
    logic [BDIV_W-1:0] bdiv;
    logic [FDIV_W-1:0] fdiv;
    logic              sel;
  } clk_cfg_t;
endpackage

// File: rtl/audio_cfg_reg.sv
module audio_cfg_reg
  import audio_clkgen_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     we_i,
  input  clk_cfg_t wdata_i,
  output clk_cfg_t cfg_o,
  output logic     reload_o
);
  clk_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_q <= '0;
    else if (we_i) cfg_q <= wdata_i;
  end

  assign cfg_o    = cfg_q;
  assign reload_o = we_i;
endmodule

// File: rtl/audio_prescaler.sv
module audio_prescaler #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         step_i,
  input  logic [W-1:0] limit_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] cnt_next_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;

  assign wrap_o     = step_i && !clear_i && (cnt_q == limit_i);
  assign cnt_next_o = (cnt_q == limit_i) ? '0 : cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (step_i)  cnt_q <= cnt_next_o;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/audio_clkgen.sv
module audio_clkgen
  import audio_clkgen_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             aux_tick_i,
  input  logic             fast_tick_i,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  output logic             bclk_en_o,
  output logic             bclk_o,
  output logic             fsync_o
);
  localparam int unsigned HW = BDIV_W + 1;

  clk_cfg_t          cfg;
  logic              reload;
  logic              src_tick;
  logic [BDIV_W-1:0] bcnt, bcnt_next;
  logic [FDIV_W-1:0] fcnt, fcnt_next;
  logic              bit_wrap, frame_wrap;
  logic [HW-1:0]     hi_len;
  logic              bclk_en_q, bclk_q, fsync_q;

  audio_cfg_reg u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (cfg_we_i),
    .wdata_i  (clk_cfg_t'(cfg_wdata_i)),
    .cfg_o    (cfg),
    .reload_o (reload)
  );

  assign src_tick = cfg.sel ? fast_tick_i : aux_tick_i;

  audio_prescaler #(.W(BDIV_W)) u_bit_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (reload),
    .step_i     (src_tick),
    .limit_i    (cfg.bdiv),
    .cnt_o      (bcnt),
    .cnt_next_o (bcnt_next),
    .wrap_o     (bit_wrap)
  );

  audio_prescaler #(.W(FDIV_W)) u_frame_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (reload),
    .step_i     (bit_wrap),
    .limit_i    (cfg.fdiv),
    .cnt_o      (fcnt),
    .cnt_next_o (fcnt_next),
    .wrap_o     (frame_wrap)
  );

  // high phase length = ceil((N+1)/2)
  assign hi_len = (HW'(cfg.bdiv) + HW'(2)) >> 1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bclk_en_q <= 1'b0;
      bclk_q    <= 1'b0;
      fsync_q   <= 1'b0;
    end else if (reload) begin
      bclk_en_q <= 1'b0;
      bclk_q    <= 1'b0;
      fsync_q   <= 1'b0;
    end else begin
      bclk_en_q <= bit_wrap;
      if (src_tick) bclk_q <= HW'(bcnt_next) < hi_len;
      if (bit_wrap) fsync_q <= frame_wrap;
    end
  end

  assign bclk_en_o = bclk_en_q;
  assign bclk_o    = bclk_q;
  assign fsync_o   = fsync_q;
endmodule

// File: rtl/audio_clkgen_chk.sv
module audio_clkgen_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        aux_tick_i,
  input logic        fast_tick_i,
  input logic        cfg_we_i,
  input logic [15:0] cfg_wdata_i,
  input logic        bclk_en_o,
  input logic        bclk_o,
  input logic        fsync_o
);
  logic sel_q, tick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sel_q <= 1'b0;
    else if (cfg_we_i) sel_q <= cfg_wdata_i[0];
  end
  assign tick = sel_q ? fast_tick_i : aux_tick_i;

  // R1
  always @(posedge clk_i)
    if (!rst_ni) reset_quiet_chk: assert (!bclk_en_o && !bclk_o && !fsync_o);

  // R2
  en_needs_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bclk_en_o |-> $past(tick && !cfg_we_i));

  // R5
  write_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> (!bclk_en_o && !bclk_o && !fsync_o));

  // R4
  fsync_on_bit_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(fsync_o) |-> (bclk_en_o || $past(cfg_we_i)));

  // R6
  bclk_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(bclk_o) |-> $past(tick || cfg_we_i));
endmodule

bind audio_clkgen audio_clkgen_chk u_chk (.*);

// File: tb/audio_clkgen_tb.sv
module audio_clkgen_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        aux_tick_i = 1'b0, fast_tick_i = 1'b0, cfg_we_i = 1'b0;
  logic [15:0] cfg_wdata_i = '0;
  logic        bclk_en_o, bclk_o, fsync_o;

  int errors = 0, checks = 0, cycles = 0;
  int since_wr = 1000;
  int m_n = 0, m_f = 0, m_sel = 0, pos = 0, fpos = 0;
  bit e_en = 0, e_bclk = 0, e_fs = 0;
  int aux_pct = 50, fast_pct = 50;
  int fs_cnt = 0, en_cnt = 0;
  bit counting = 0;

  audio_clkgen u_dut (.*);

  always #10 clk_i = ~clk_i;

  task automatic chk(input bit act, input bit exp, input string req, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s t=%0t act=%0b exp=%0b", req, what, $time, act, exp);
    end
  endtask

  // behavioural reference: positions within bit period and frame
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_n = 0; m_f = 0; m_sel = 0; pos = 0; fpos = 0;
      e_en = 0; e_bclk = 0; e_fs = 0;
    end else begin
      bit t;
      t = m_sel ? fast_tick_i : aux_tick_i;
      since_wr++;
      e_en = 0;
      if (cfg_we_i) begin
        m_n = cfg_wdata_i[15:8]; m_f = cfg_wdata_i[7:1]; m_sel = cfg_wdata_i[0];
        pos = 0; fpos = 0; e_bclk = 0; e_fs = 0; since_wr = 0;
      end else if (t) begin
        if (pos == m_n) begin
          e_en = 1; pos = 0;
          e_fs = (fpos == m_f);
          fpos = (fpos == m_f) ? 0 : fpos + 1;
        end else pos++;
        e_bclk = pos < (m_n + 2) / 2;
      end
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni) begin
      string rq;
      cycles++;
      rq = (since_wr <= m_n + 2) ? "R5" : (m_sel != 0 ? "R2" : "R3");
      chk(bclk_en_o, e_en, rq, "bclk_en");
      chk(bclk_o, e_bclk, "R6", "bclk");
      chk(fsync_o, e_fs, (m_f == 0) ? "R7" : "R4", "fsync");
      if (counting) begin
        en_cnt += bclk_en_o;
        fs_cnt += (bclk_en_o && fsync_o);
      end
      if (cycles > 150000) begin
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      aux_tick_i  = ($urandom_range(99) < aux_pct);
      fast_tick_i = ($urandom_range(99) < fast_pct);
      cfg_we_i    = 1'b0;
    end
  endtask

  task automatic wr(input int n, input int f, input bit s);
    @(negedge clk_i);
    cfg_we_i = 1'b1;
    cfg_wdata_i = {n[7:0], f[6:0], s};
    aux_tick_i = 1'b1; fast_tick_i = 1'b1;  // strobe collides with write
  endtask

  initial begin
    #5;
    @(negedge clk_i);
    // R1
    chk(bclk_en_o, 1'b0, "R1", "reset bclk_en");
    chk(bclk_o, 1'b0, "R1", "reset bclk");
    chk(fsync_o, 1'b0, "R1", "reset fsync");
    rst_ni = 1'b1;
    run(200);                     // reset config: aux, ratio 1
    wr(3, 2, 0); run(600);
    aux_pct = 20; fast_pct = 90;
    wr(3, 2, 1); run(600);        // R2 source switch only
    wr(4, 0, 1); run(500);        // R7
    aux_pct = 100; fast_pct = 30;
    wr(5, 3, 0); run(400);
    for (int k = 0; k < 40; k++) begin
      wr($urandom_range(6), $urandom_range(4), $urandom_range(1));
      run($urandom_range(5, 60));
    end
    // R8: 8 kHz frame from 1024 kHz bit clock
    aux_pct = 100;
    wr(1, 127, 0);
    run(3);
    counting = 1;
    run(2 * 128 * 3);
    counting = 0;
    checks++;
    if (fs_cnt * 128 != en_cnt) begin
      errors++;
      $display("FAIL R8 frames act=%0d exp=%0d", fs_cnt, en_cnt / 128);
    end
    wr(0, 0, 0); run(50);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule